// File: doc/BRIEF.md
# Circular Buffer with Last-Operation Flag

This block is a single-clock producer/consumer ring buffer. A producer writes words through a put port and a consumer reads them back, in arrival order, through a get port. Storage is a fixed array addressed by two binary indices: a put index and a get index. Each index steps by one per accepted operation and returns to location zero after the last location. The get index always trails the put index.

The indices carry no extra wrap bit, and the block keeps no occupancy count. When the two indices match, a one-bit record of the most recent single operation tells the two cases apart. If that operation was a put, the ring is full. If it was a get, the ring is empty. A put attempted while the ring is full is discarded and latches a sticky overflow flag, which the consumer clears with a dedicated input. A get attempted while the ring is empty does nothing.

The depth must be a power of two, and it sets the index width. The word width is a separate parameter.

Top module: `ringq_top`

## Requirements
- R1: While reset is low and in the cycle after it is released, empty is 1, full is 0, overflow is 0 and getData is 0.
- R2: Words are returned in the order they were accepted. When a get is accepted at a clock edge, getData shows the oldest stored word from that edge onward.
- R3: Both indices wrap from location DEPTH-1 to location 0, so ordering stays correct across any number of passes around the ring.
- R4: A lone get that leaves the indices equal makes empty 1 and full 0 after that edge.
- R5: DEPTH accepted puts with no gets in between make full 1 and empty 0 after the last edge.
- R6: A put while full is dropped. The stored words and both indices are unchanged, and overflow is 1 after that edge.
- R7: Once set, overflow stays 1 until a cycle with ovfClr high and no overflowing put, after which it is 0. If an overflowing put and ovfClr occur in the same cycle, overflow stays set.
- R8: A get while empty is ignored. getData keeps its previous value and empty stays 1 unless a put is accepted in the same cycle.
- R9: A put and a get in the same cycle while neither empty nor full are both accepted. The occupancy and the empty and full outputs are unchanged.
- R10: Empty + put + get in one cycle accepts only the put (empty becomes 0, getData holds). Full + put + get in one cycle accepts only the get (full becomes 0, overflow becomes 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| putValid | input | 1 | Request to store putData |
| putData | input | WIDTH | Word to store |
| getValid | input | 1 | Request to remove the oldest word |
| getData | output | WIDTH | Most recently removed word (registered) |
| ovfClr | input | 1 | Clears the sticky overflow flag |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| overflow | output | 1 | Sticky: a put arrived while full |

## Verification
The embedded properties check the following on every cycle:
- a get strobe is required for getData to change;
- overflow sets after an overflowing put and stays set until cleared;
- full and empty can only rise after a put and a get respectively;
- a simultaneous put and get leaves the flags in the states given by R9 and R10.

The content of the ring can only be shown by the bench's scenarios, which compare every returned word against a reference queue. These scenarios cover:
- word ordering across several wraps;
- proof that a dropped put left the stored data intact;
- the choice between set and clear for overflow when both occur in the same cycle.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic wrEn;  // store the incoming word and advance the put index
    logic rdEn;  // load the oldest word and advance the get index
  } ringq_strobe_t;

endpackage

// File: rtl/ringq_datapath.sv
module ringq_datapath
  import ringq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringq_strobe_t    strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             ptrEq
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0]    putPtr;
  logic [AW-1:0]    getPtr;
  logic [WIDTH-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[putPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      putPtr <= '0;
      getPtr <= '0;
    end else begin
      if (strobe.wrEn) putPtr <= stepPtr(putPtr);
      if (strobe.rdEn) getPtr <= stepPtr(getPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= mem[getPtr];
  end

  assign ptrEq = (putPtr == getPtr);

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(rdData)); // R8

  AST_PUT_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn && !strobe.rdEn && ptrEq |=> !ptrEq); // R3

endmodule

// File: rtl/ringq_control.sv
module ringq_control
  import ringq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          putValid,
  input  logic          getValid,
  input  logic          ovfClr,
  input  logic          ptrEq,
  output ringq_strobe_t strobe,
  output logic          empty,
  output logic          full,
  output logic          overflow
);

  logic lastWasPut;
  logic ovfReg;
  logic acceptPut;
  logic acceptGet;

  assign empty     = ptrEq && !lastWasPut;
  assign full      = ptrEq && lastWasPut;
  assign acceptPut = putValid && !full;
  assign acceptGet = getValid && !empty;

  always_comb begin
    strobe      = '0;
    strobe.wrEn = acceptPut;
    strobe.rdEn = acceptGet;
  end

  // Only a lone operation changes the record.
  always_ff @(posedge clk) begin
    if (!rstN)                         lastWasPut <= 1'b0;
    else if (acceptPut && !acceptGet)  lastWasPut <= 1'b1;
    else if (acceptGet && !acceptPut)  lastWasPut <= 1'b0;
  end

  // Sticky overflow. A new overflow wins over a clear.
  always_ff @(posedge clk) begin
    if (!rstN)                 ovfReg <= 1'b0;
    else if (putValid && full) ovfReg <= 1'b1;
    else if (ovfClr)           ovfReg <= 1'b0;
  end

  assign overflow = ovfReg;

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rstN)
    putValid && full |=> overflow); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !ovfClr |=> overflow); // R7

  AST_FULL_AFTER_PUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(full) |-> $past(strobe.wrEn)); // R5

  AST_EMPTY_AFTER_GET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(empty) |-> $past(strobe.rdEn)); // R4

endmodule

// File: rtl/ringq_top.sv
module ringq_top
  import ringq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             putValid,
  input  logic [WIDTH-1:0] putData,
  input  logic             getValid,
  output logic [WIDTH-1:0] getData,
  input  logic             ovfClr,
  output logic             empty,
  output logic             full,
  output logic             overflow
);

  ringq_strobe_t strobe;
  logic          ptrEq;

  ringq_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .putValid (putValid),
    .getValid (getValid),
    .ovfClr   (ovfClr),
    .ptrEq    (ptrEq),
    .strobe   (strobe),
    .empty    (empty),
    .full     (full),
    .overflow (overflow)
  );

  ringq_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (putData),
    .rdData (getData),
    .ptrEq  (ptrEq)
  );

  AST_FULL_PUT_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    full && putValid && !getValid |=> full); // R6

  AST_SIMUL_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    putValid && getValid && !empty && !full |=> !empty && !full); // R9

  AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    empty && putValid && getValid |=> !empty && $stable(getData)); // R10

  AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    full && putValid && getValid |=> !full && overflow); // R10

endmodule

// File: tb/tb_ringq_top.sv
`timescale 1ns/1ps
module tb_ringq_top;

  localparam int DP = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          putValid;
  logic [DW-1:0] putData;
  logic          getValid;
  logic [DW-1:0] getData;
  logic          ovfClr;
  logic          empty;
  logic          full;
  logic          overflow;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mq[$];    // reference contents
  logic [DW-1:0] expQ[$];  // scoreboard of expected reads
  logic          modelOvf = 1'b0;
  logic [DW-1:0] modelLast = '0;
  logic          rdGo = 1'b0;
  logic          armQ = 1'b0;

  always #4 clk = ~clk;

  ringq_top #(.DEPTH(DP), .WIDTH(DW)) dut (
    .clk(clk), .rstN(rstN), .putValid(putValid), .putData(putData),
    .getValid(getValid), .getData(getData), .ovfClr(ovfClr),
    .empty(empty), .full(full), .overflow(overflow)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare each returned word with the scoreboard.
  always @(posedge clk) armQ <= rdGo;
  always @(negedge clk) begin
    if (armQ) begin
      if (expQ.size() == 0) check("R2", "unexpected read", 64'd1, 64'd0);
      else check("R2", "read order", 64'(getData), 64'(expQ.pop_front()));
    end
  end

  // Driver: one cycle of stimulus plus flag checks, called at a negedge.
  task automatic step(input logic pv, input logic [DW-1:0] pd,
                      input logic gv, input logic clr, input string tag);
    int  cnt  = mq.size();
    logic aGet = gv && cnt > 0;
    logic aPut = pv && cnt < DP;
    if (aGet) begin
      modelLast = mq.pop_front();
      expQ.push_back(modelLast);
    end
    if (aPut) mq.push_back(pd);
    if (pv && cnt == DP) modelOvf = 1'b1;
    else if (clr)        modelOvf = 1'b0;
    putValid = pv; putData = pd; getValid = gv; ovfClr = clr; rdGo = aGet;
    @(posedge clk);
    @(negedge clk);
    putValid = 1'b0; getValid = 1'b0; ovfClr = 1'b0; rdGo = 1'b0;
    check(tag, "empty", 64'(empty), 64'(mq.size() == 0));
    check(tag, "full", 64'(full), 64'(mq.size() == DP));
    check(tag, "overflow", 64'(overflow), 64'(modelOvf));
    if (gv && !aGet) check(tag, "held data", 64'(getData), 64'(modelLast));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; putValid = 1'b0; putData = '0; getValid = 1'b0; ovfClr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "empty in reset", 64'(empty), 64'd1);
    check("R1", "full in reset", 64'(full), 64'd0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", "empty", 64'(empty), 64'd1);
    check("R1", "full", 64'(full), 64'd0);
    check("R1", "overflow", 64'(overflow), 64'd0);
    check("R1", "getData", 64'(getData), 64'd0);

    // R8: get on empty
    step(1'b0, 8'h00, 1'b1, 1'b0, "R8");
    step(1'b0, 8'h00, 1'b1, 1'b0, "R8");

    // R2/R4: short burst in and out
    for (int i = 0; i < 3; i++) step(1'b1, 8'h10 + 8'(i), 1'b0, 1'b0, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b1, 1'b0, "R8");

    // R5: fill (indices start at 3, so this wraps)
    for (int i = 0; i < DP; i++) step(1'b1, 8'hA0 + 8'(i), 1'b0, 1'b0, "R5");
    // R6: overflowing puts are dropped
    step(1'b1, 8'hEE, 1'b0, 1'b0, "R6");
    step(1'b1, 8'hEF, 1'b0, 1'b0, "R6");
    // R7: sticky while idle, set wins over clear, then clear
    step(1'b0, 8'h00, 1'b0, 1'b0, "R7");
    step(1'b1, 8'hED, 1'b0, 1'b1, "R7");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R7");
    step(1'b0, 8'h00, 1'b0, 1'b0, "R7");
    // R3: drain across the wrap; dropped words must not appear
    for (int i = 0; i < DP; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R3");

    // R9: steady put+get at mid occupancy for several passes
    for (int i = 0; i < 4; i++) step(1'b1, 8'h30 + 8'(i), 1'b0, 1'b0, "R9");
    for (int i = 0; i < 3 * DP; i++) step(1'b1, 8'h50 + 8'(i), 1'b1, 1'b0, "R9");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R3");

    // R10: both strobes while empty, then while full
    step(1'b1, 8'hC1, 1'b1, 1'b0, "R10");
    for (int i = 0; i < DP - 1; i++) step(1'b1, 8'hC2 + 8'(i), 1'b0, 1'b0, "R5");
    step(1'b1, 8'hDD, 1'b1, 1'b0, "R10");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R7");
    for (int i = 0; i < DP; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R2");
    step(1'b0, 8'h00, 1'b1, 1'b0, "R8");

    @(negedge clk);
    check("R2", "scoreboard drained", 64'(expQ.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule